// File: doc/BRIEF.md
# Serial-Addressed Read-Only Word Store

The block holds 512 words of 16 bits each and reads them through a narrow serial port. A caller loads a 9-bit read address one bit at a time into an address register. It then captures the addressed word into a 16-bit output shift register and clocks that word out one bit at a time on a single serial output. Reset fills the array with a fixed, predictable pattern: word = address XOR `KEY`, where `KEY` defaults to 16'hA5A5.

There are two read modes. A standard read is a full serial address load followed by one capture and shift-out. A stream read steps the address register forward by one with a single address strobe, without reloading the address, so consecutive words can be fetched in turn. Every change to the address starts a settle window of two clock cycles. During that window `busy` is high and capture requests are refused. The window is tracked by a small state machine with three states:

- `ST_IDLE`: no settle window is running.
- `ST_SETTLE_A`: first cycle after an address change.
- `ST_SETTLE_B`: second cycle after an address change.

Its transitions are:

- From any state, an address strobe moves it to `ST_SETTLE_A`. This is the restart when the strobe arrives mid-window.
- With no strobe, `ST_SETTLE_A` moves to `ST_SETTLE_B`.
- With no strobe, `ST_SETTLE_B` moves to `ST_IDLE`.
- With no strobe, `ST_IDLE` stays in `ST_IDLE`.

All strobes are single-cycle enables sampled on the rising edge of `clk`.

Top module: `sam_read_port`

## Requirements
- R1: After reset the address register is 0, the output shift register is 0 (so `ser_out` is 0), and `busy` is 0.
- R2: On an edge with `adr_stb`=1 and `adr_shift`=1, the address register shifts left by one and takes `adr_sdi` into bit 0. Nine such edges therefore load an address sent MSB first.
- R3: On an edge with `adr_stb`=1 and `adr_shift`=0, the address register increments by one.
- R4: Incrementing from address 511 gives address 0.
- R5: On an edge with `dat_stb`=1, `dat_load`=1 and `busy`=0, the output shift register captures the word at the current address, which is address XOR 16'hA5A5 after reset.
- R6: On an edge with `dat_stb`=1 and `dat_load`=0, the output shift register shifts left and fills bit 0 with 0. `ser_out` always shows bit 15, so a word leaves MSB first.
- R7: `busy` is 1 during exactly the two clock cycles that follow any edge where `adr_stb`=1. A further strobe restarts the window.
- R8: A capture request (`dat_stb`=1, `dat_load`=1) on an edge where `busy`=1 leaves the output shift register unchanged.
- R9: A stream of address increments, each followed by a capture and shift-out, returns consecutive words without any address reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| adr_stb | input | 1 | Address-step strobe (one edge of the address clock) |
| adr_shift | input | 1 | 1: shift `adr_sdi` in; 0: increment address |
| adr_sdi | input | 1 | Serial address bit |
| dat_stb | input | 1 | Data-step strobe (one edge of the data clock) |
| dat_load | input | 1 | 1: parallel capture; 0: shift out |
| ser_out | output | 1 | Serial data output, MSB of the shift register |
| busy | output | 1 | Settle window active after an address change |

## Verification
The checker assumes that the strobes and their mode controls are clean synchronous levels while `rst_n` is high. It also assumes that `adr_stb` is 0 during reset. Without that, the settle-window property could see a strobe from before reset release. The bench changes inputs only one time unit after a rising edge and holds every strobe low through reset. Captures are made only after `busy` has dropped, except in the one scenario that deliberately requests a capture inside the window to show that it is refused.

// File: rtl/sam_pkg.sv
package sam_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE_A,
        ST_SETTLE_B
    } settle_st_t;

    function automatic logic [31:0] seed_word(input int unsigned idx, input logic [31:0] key);
        return idx ^ key;
    endfunction

endpackage

// File: rtl/sam_addr_reg.sv
module sam_addr_reg #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              shift_en,
    input  logic              sdi,
    output logic [ADDR_W-1:0] addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (step) begin
            if (shift_en) addr <= {addr[ADDR_W-2:0], sdi};
            else          addr <= addr + 1'b1;   // natural wrap at top
        end
    end

endmodule

// File: rtl/sam_settle_fsm.sv
module sam_settle_fsm
    import sam_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic addr_moved,
    output logic busy
);

    settle_st_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     state_nx = addr_moved ? ST_SETTLE_A : ST_IDLE;
            ST_SETTLE_A: state_nx = addr_moved ? ST_SETTLE_A : ST_SETTLE_B;
            ST_SETTLE_B: state_nx = addr_moved ? ST_SETTLE_A : ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_SETTLE_A, ST_SETTLE_B: busy = 1'b1;
            default:                  busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/sam_store.sv
module sam_store
    import sam_pkg::*;
#(
    parameter int              ADDR_W = 9,
    parameter int              DATA_W = 16,
    parameter logic [DATA_W-1:0] KEY  = 16'hA5A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Contents are established at reset and then held.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= DATA_W'(seed_word(i, 32'(KEY)));
        end else begin
            cells <= cells;
        end
    end

    assign rd_word = cells[rd_addr];

endmodule

// File: rtl/sam_out_sreg.sv
module sam_out_sreg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load,
    input  logic              hold_off,
    input  logic [DATA_W-1:0] par_in,
    output logic [DATA_W-1:0] word
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (step) begin
            if (!load)          word <= {word[DATA_W-2:0], 1'b0};
            else if (!hold_off) word <= par_in;
        end
    end

endmodule

// File: rtl/sam_read_port.sv
module sam_read_port #(
    parameter int                ADDR_W = 9,
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] KEY    = 16'hA5A5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adr_stb,
    input  logic adr_shift,
    input  logic adr_sdi,
    input  logic dat_stb,
    input  logic dat_load,
    output logic ser_out,
    output logic busy
);

    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] shift_word;

    sam_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (adr_stb),
        .shift_en (adr_shift),
        .sdi      (adr_sdi),
        .addr     (cur_addr)
    );

    sam_settle_fsm u_settle (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_moved (adr_stb),
        .busy       (busy)
    );

    sam_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (cur_addr),
        .rd_word (arr_word)
    );

    sam_out_sreg #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (dat_stb),
        .load     (dat_load),
        .hold_off (busy),
        .par_in   (arr_word),
        .word     (shift_word)
    );

    assign ser_out = shift_word[DATA_W-1];

endmodule

// File: rtl/sam_read_port_chk.sv
module sam_read_port_chk #(
    parameter int                ADDR_W = 9,
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] KEY    = 16'hA5A5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adr_stb,
    input logic              adr_shift,
    input logic              adr_sdi,
    input logic              dat_stb,
    input logic              dat_load,
    input logic              busy,
    input logic [ADDR_W-1:0] addr_q,
    input logic [DATA_W-1:0] word_q
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adr_stb && adr_shift |=> addr_q == {$past(addr_q[ADDR_W-2:0]), $past(adr_sdi)});

    p_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adr_stb && !adr_shift |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adr_stb && !adr_shift && addr_q == TOP_ADDR |=> addr_q == '0);

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dat_stb && dat_load && !busy |=> word_q == (DATA_W'($past(addr_q)) ^ KEY));

    p_shift_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dat_stb && !dat_load |=> word_q == {$past(word_q[DATA_W-2:0]), 1'b0});

    p_busy_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy == ($past(adr_stb) || $past(adr_stb, 2)));

    p_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dat_stb && dat_load && busy |=> word_q == $past(word_q));

endmodule

bind sam_read_port sam_read_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adr_stb   (adr_stb),
    .adr_shift (adr_shift),
    .adr_sdi   (adr_sdi),
    .dat_stb   (dat_stb),
    .dat_load  (dat_load),
    .busy      (busy),
    .addr_q    (cur_addr),
    .word_q    (shift_word)
);

// File: tb/tb_sam_read_port.sv
`timescale 1ns/1ps
module tb_sam_read_port;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adr_stb = 1'b0, adr_shift = 1'b0, adr_sdi = 1'b0;
    logic dat_stb = 1'b0, dat_load = 1'b0;
    logic ser_out, busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sam_read_port dut (
        .clk(clk), .rst_n(rst_n),
        .adr_stb(adr_stb), .adr_shift(adr_shift), .adr_sdi(adr_sdi),
        .dat_stb(dat_stb), .dat_load(dat_load),
        .ser_out(ser_out), .busy(busy)
    );

    function automatic logic [15:0] expect_word(input logic [8:0] a);
        return {7'd0, a} ^ 16'hA5A5;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        adr_stb = 0; adr_shift = 0; adr_sdi = 0; dat_stb = 0; dat_load = 0;
    endtask

    // R2: nine shifts, MSB first; then wait out the settle window.
    task automatic load_addr(input logic [8:0] a);
        for (int i = 8; i >= 0; i--) begin
            adr_stb = 1; adr_shift = 1; adr_sdi = a[i];
            tick();
        end
        idle_inputs();
        tick(); tick();
    endtask

    task automatic bump_addr();
        adr_stb = 1; adr_shift = 0;
        tick();
        idle_inputs();
        tick(); tick();
    endtask

    task automatic capture();
        dat_stb = 1; dat_load = 1;
        tick();
        idle_inputs();
    endtask

    // R6: read bit 15 first, shift after each bit.
    task automatic drain(output logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            w[i] = ser_out;
            dat_stb = 1; dat_load = 0;
            tick();
        end
        idle_inputs();
    endtask

    task automatic t_reset();
        check("R1 busy", 32'(busy), 0);
        check("R1 ser_out", 32'(ser_out), 0);
        begin
            logic [15:0] w;
            drain(w);
            check("R1 data reg zero", 32'(w), 0);
        end
        capture();   // address 0 after reset
        begin
            logic [15:0] w;
            drain(w);
            check("R1 addr zero (word at 0)", 32'(w), 32'(expect_word(9'd0)));
        end
    endtask

    task automatic t_standard_read();
        logic [15:0] w;
        load_addr(9'h13C);
        capture();
        check("R5 ser_out msb after capture", 32'(ser_out), 32'(expect_word(9'h13C) >> 15));
        drain(w);
        check("R2 R5 R6 standard read 0x13C", 32'(w), 32'(expect_word(9'h13C)));
        drain(w);
        check("R6 zero fill", 32'(w), 0);
        load_addr(9'h0A7);
        capture(); drain(w);
        check("R2 standard read 0x0A7", 32'(w), 32'(expect_word(9'h0A7)));
    endtask

    task automatic t_busy_window();
        adr_stb = 1; adr_shift = 0;
        tick();
        idle_inputs();
        check("R7 busy cycle 1", 32'(busy), 1);
        tick();
        check("R7 busy cycle 2", 32'(busy), 1);
        adr_stb = 1; adr_shift = 0;   // restart mid-window
        tick();
        idle_inputs();
        check("R7 busy restart", 32'(busy), 1);
        tick();
        check("R7 busy restart cycle 2", 32'(busy), 1);
        tick();
        check("R7 busy clear", 32'(busy), 0);
    endtask

    task automatic t_refused_capture();
        logic [15:0] w;
        load_addr(9'h040);
        capture();                    // word of 0x040 held
        adr_stb = 1; adr_shift = 0;   // address moves to 0x041
        tick();
        idle_inputs();
        dat_stb = 1; dat_load = 1;    // busy now: refused
        tick();
        idle_inputs();
        tick();
        drain(w);
        check("R8 capture refused while busy", 32'(w), 32'(expect_word(9'h040)));
        capture(); drain(w);
        check("R8 R3 capture after window", 32'(w), 32'(expect_word(9'h041)));
    endtask

    task automatic t_stream();
        logic [15:0] w;
        load_addr(9'h005);
        capture(); drain(w);
        check("R9 stream word 0", 32'(w), 32'(expect_word(9'h005)));
        for (int k = 1; k <= 5; k++) begin
            bump_addr();
            capture(); drain(w);
            check($sformatf("R3 R9 stream word %0d", k), 32'(w), 32'(expect_word(9'(5 + k))));
        end
    endtask

    task automatic t_wrap();
        logic [15:0] w;
        load_addr(9'd510);
        bump_addr();
        capture(); drain(w);
        check("R4 word at 511", 32'(w), 32'(expect_word(9'd511)));
        bump_addr();
        capture(); drain(w);
        check("R4 wrap to 0", 32'(w), 32'(expect_word(9'd0)));
        bump_addr();
        capture(); drain(w);
        check("R4 after wrap 1", 32'(w), 32'(expect_word(9'd1)));
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_standard_read();
        t_busy_window();
        t_refused_capture();
        t_stream();
        t_wrap();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule